// File: doc/BRIEF.md
# Reset Source Arbiter with Cause Register

This block merges every reset request on the chip into a single system reset and keeps a byte that tells software what caused the most recent one. The requests are: an asynchronous power-up signal, an active-low external reset pin, a watchdog expiry, an illegal-instruction flag from the decoder, a clock-generator fault, a low-supply trip and a reset forced by the debug host. Enable inputs qualify the watchdog and low-supply requests, and a stop-mode input gates low-supply detection further.

While any qualified request is present, the system reset output is held high. It stays high for a fixed stretch after the last request goes away. In the cycle where the reset first rises, the cause byte takes a snapshot of the requests that are present. The power-up input sets the byte directly and asynchronously. The byte then survives every later reset until the next capture.

Software reads the byte through a small address/write bus. The byte cannot be written. A write of any data to its address does not change it. Instead, the write produces a one-cycle strobe that restarts the watchdog.

Top module: `rstc_top`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1 and the cause byte is 0x82. After `por_n` rises, `sys_rst` stays 1 for exactly 16 clock cycles and then falls. The byte stays 0x82 after that.
- R2: Cause byte layout: bit 7 power-up, bit 6 external pin, bit 5 watchdog, bit 4 illegal instruction, bit 2 clock fault, bit 1 low supply. Bits 3 and 0 always read 0.
- R3: When reset is first asserted, each bit whose source is active in that cycle is set and every other bit is cleared. Simultaneous sources set all of their bits.
- R4: A debug-forced reset asserts `sys_rst` and leaves the cause byte at 0x00, even when other sources are active in the same cycle.
- R5: A watchdog expiry causes a reset only when `wdog_en` is 1. Otherwise `sys_rst` stays 0 and the byte is unchanged.
- R6: A low-supply trip causes a reset only when both `lv_det_en` and `lv_rst_en` are 1.
- R7: While `stop_mode` is 1, a low-supply trip is ignored unless `lv_stop_en` is 1.
- R8: The external pin passes through a two-flop synchronizer. `sys_rst` rises on the third rising edge after the pin goes low. After the pin is released, the reset lasts 18 cycles in total.
- R9: `sys_rst` stays 1 for 16 cycles after the last qualified source goes inactive. A source that appears during this stretch restarts the count.
- R10: A write to address 0x18 drives `wdog_clr` high for exactly the following cycle and leaves the cause byte unchanged. A write to any other address gives no strobe.
- R11: The cause byte is captured only in the cycle where reset first rises. Sources that appear while reset is already asserted do not change it.
- R12: `rd_data` shows the cause byte when `bus_addr` is 0x18 and shows 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_expire | input | 1 | Watchdog timer expired |
| wdog_en | input | 1 | Watchdog reset enable |
| illop_req | input | 1 | Illegal-instruction flag from the decoder |
| clkmod_fault | input | 1 | Clock generator fault request |
| lv_trip | input | 1 | Low-supply comparator tripped |
| lv_det_en | input | 1 | Low-supply detection enable |
| lv_rst_en | input | 1 | Low-supply reset enable |
| lv_stop_en | input | 1 | Keep low-supply detection active in stop |
| stop_mode | input | 1 | Device is in stop mode |
| dbg_force | input | 1 | Reset forced by the debug host |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| rd_data | output | 8 | Read data (cause byte or zero) |
| wdog_clr | output | 1 | One-cycle watchdog restart strobe |
| sys_rst | output | 1 | System reset, active high |

## Verification
The assertions check four things on every cycle:
- any qualified request makes the reset high on the next cycle with the stretch counter reloaded;
- the cause byte cannot move outside a capture cycle;
- a debug-forced capture yields zero;
- a write to the cause address is always followed by the restart strobe, and the reserved bits always read zero.

Only the directed scenarios can show the rest:
- the exact snapshot values for each source;
- the enable and stop-mode gating;
- the 16- and 18-cycle stretch lengths;
- the synchronizer latency;
- the fact that a late source reloads the stretch without changing the byte.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int unsigned CAUSE_W = 8;

    // Cause byte bit positions (software decodes these)
    localparam int unsigned BIT_PWR = 7;
    localparam int unsigned BIT_PIN = 6;
    localparam int unsigned BIT_WDT = 5;
    localparam int unsigned BIT_ILL = 4;
    localparam int unsigned BIT_CLK = 2;
    localparam int unsigned BIT_LV  = 1;

    localparam logic [CAUSE_W-1:0] RSVD_MASK = 8'h09;

    typedef struct packed {
        logic pin;
        logic wdt;
        logic ill;
        logic clk;
        logic lv;
    } rst_req_t;

    function automatic logic [CAUSE_W-1:0] pwrup_cause();
        logic [CAUSE_W-1:0] c;
        c = '0;
        c[BIT_PWR] = 1'b1;
        c[BIT_LV]  = 1'b1;
        return c;
    endfunction

    function automatic logic [CAUSE_W-1:0] pack_cause(rst_req_t r, logic dbg);
        logic [CAUSE_W-1:0] c;
        c = '0;
        if (!dbg) begin
            c[BIT_PIN] = r.pin;
            c[BIT_WDT] = r.wdt;
            c[BIT_ILL] = r.ill;
            c[BIT_CLK] = r.clk;
            c[BIT_LV]  = r.lv;
        end
        return c;
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.sh <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.sh[STAGES-1];

endmodule

// File: rtl/rstc_qual.sv
module rstc_qual
    import rstc_pkg::*;
(
    input  logic     pin_n_sync,
    input  logic     wdog_expire,
    input  logic     wdog_en,
    input  logic     illop_req,
    input  logic     clkmod_fault,
    input  logic     lv_trip,
    input  logic     lv_det_en,
    input  logic     lv_rst_en,
    input  logic     lv_stop_en,
    input  logic     stop_mode,
    input  logic     dbg_force,
    output rst_req_t req,
    output logic     dbg_req,
    output logic     any_req
);

    logic lv_armed;

    always_comb begin
        // low-supply detection is switched off in stop unless kept alive
        lv_armed = lv_det_en && lv_rst_en && (!stop_mode || lv_stop_en);

        req.pin = !pin_n_sync;
        req.wdt = wdog_expire && wdog_en;
        req.ill = illop_req;
        req.clk = clkmod_fault;
        req.lv  = lv_trip && lv_armed;

        dbg_req = dbg_force;
        any_req = (|req) || dbg_req;
    end

endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
    parameter int unsigned HOLD_CYC = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic trig,
    output logic sys_rst,
    output logic cap_en
);

    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.cnt = CNT_LOAD;
            st_d.rst = 1'b1;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            st_d.rst = 1'b1;
        end else begin
            st_d.rst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.cnt <= CNT_LOAD;
            st_q.rst <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst = st_q.rst;
    assign cap_en  = trig && !st_q.rst;

    AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (!arst_n)
        trig |=> (sys_rst && st_q.cnt == CNT_LOAD)); // R9

endmodule

// File: rtl/rstc_stat.sv
module rstc_stat
    import rstc_pkg::*;
#(
    parameter int unsigned           ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]     STAT_ADDR = ADDR_W'('h18)
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic                cap_en,
    input  rst_req_t            req,
    input  logic                dbg_req,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    output logic [CAUSE_W-1:0]  rd_data,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic                wdog_clr
);

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic               wclr;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        hit  = (bus_addr == STAT_ADDR);
        st_d = st_q;
        if (cap_en) begin
            st_d.cause = pack_cause(req, dbg_req);
        end
        // write data is discarded: the byte is read-only
        st_d.wclr = bus_wr && hit;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.cause <= pwrup_cause();
            st_q.wclr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = hit ? st_q.cause : '0;
    assign cause_o  = st_q.cause;
    assign wdog_clr = st_q.wclr;

    AST_WCLR_AFTER_WR: assert property (@(posedge clk) disable iff (!arst_n)
        (bus_wr && bus_addr == STAT_ADDR) |=> wdog_clr); // R10
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!arst_n)
        !cap_en |=> $stable(cause_o)); // R11

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = ADDR_W'('h18),
    parameter int unsigned       HOLD_CYC    = 16,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              wdog_expire,
    input  logic              wdog_en,
    input  logic              illop_req,
    input  logic              clkmod_fault,
    input  logic              lv_trip,
    input  logic              lv_det_en,
    input  logic              lv_rst_en,
    input  logic              lv_stop_en,
    input  logic              stop_mode,
    input  logic              dbg_force,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    output logic [7:0]        rd_data,
    output logic              wdog_clr,
    output logic              sys_rst
);

    logic               pin_n_sync;
    rst_req_t           req;
    logic               dbg_req;
    logic               any_req;
    logic               cap_en;
    logic [CAUSE_W-1:0] cause;

    rstc_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_pin_sync (
        .clk    (clk),
        .arst_n (por_n),
        .din    (ext_rst_n),
        .dout   (pin_n_sync)
    );

    rstc_qual u_qual (
        .pin_n_sync   (pin_n_sync),
        .wdog_expire  (wdog_expire),
        .wdog_en      (wdog_en),
        .illop_req    (illop_req),
        .clkmod_fault (clkmod_fault),
        .lv_trip      (lv_trip),
        .lv_det_en    (lv_det_en),
        .lv_rst_en    (lv_rst_en),
        .lv_stop_en   (lv_stop_en),
        .stop_mode    (stop_mode),
        .dbg_force    (dbg_force),
        .req          (req),
        .dbg_req      (dbg_req),
        .any_req      (any_req)
    );

    rstc_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk     (clk),
        .arst_n  (por_n),
        .trig    (any_req),
        .sys_rst (sys_rst),
        .cap_en  (cap_en)
    );

    rstc_stat #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR)
    ) u_stat (
        .clk      (clk),
        .arst_n   (por_n),
        .cap_en   (cap_en),
        .req      (req),
        .dbg_req  (dbg_req),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .rd_data  (rd_data),
        .cause_o  (cause),
        .wdog_clr (wdog_clr)
    );

    AST_REQ_RAISES_RST: assert property (@(posedge clk) disable iff (!por_n)
        any_req |=> sys_rst); // R9
    AST_DBG_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && dbg_force) |=> (cause == '0)); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data & RSVD_MASK) == '0); // R2

endmodule

// File: tb/rstc_top_tb_top.sv
module rstc_top_tb_top;

    localparam logic [7:0] STAT = 8'h18;

    logic       clk = 1'b0;
    logic       por_n, ext_rst_n, wdog_expire, wdog_en, illop_req, clkmod_fault;
    logic       lv_trip, lv_det_en, lv_rst_en, lv_stop_en, stop_mode, dbg_force;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic [7:0] rd_data;
    logic       wdog_clr, sys_rst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rstc_top dut_i (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .wdog_expire(wdog_expire), .wdog_en(wdog_en), .illop_req(illop_req),
        .clkmod_fault(clkmod_fault), .lv_trip(lv_trip), .lv_det_en(lv_det_en),
        .lv_rst_en(lv_rst_en), .lv_stop_en(lv_stop_en), .stop_mode(stop_mode),
        .dbg_force(dbg_force), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .rd_data(rd_data), .wdog_clr(wdog_clr), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one edge later: reset must be up and the byte captured
    task automatic hit(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, "sys_rst asserted", sys_rst, 1);
        chk(req, "cause byte", rd_data, exp);
    endtask

    task automatic hold_len(input string req, input int exp);
        int n = 0;
        @(negedge clk);
        while (sys_rst === 1'b1 && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk(req, "stretch length", n, exp);
    endtask

    task automatic quiet(input string req, input logic [7:0] exp);
        repeat (4) @(negedge clk);
        chk(req, "no reset", sys_rst, 0);
        chk(req, "byte unchanged", rd_data, exp);
    endtask

    task automatic t_por();
        repeat (3) @(negedge clk);
        chk("R1", "reset during power-up", sys_rst, 1);
        chk("R2", "power-up byte", rd_data, 8'h82);
        chk("R10", "no strobe at power-up", wdog_clr, 0);
        por_n = 1'b1;
        hold_len("R1", 16);
        chk("R1", "byte kept after power-up", rd_data, 8'h82);
    endtask

    task automatic wdog_reset();
        wdog_en = 1'b1; wdog_expire = 1'b1;
        hit("R5", 8'h20);
        wdog_expire = 1'b0;
        hold_len("R9", 16);
        chk("R3", "watchdog byte persists", rd_data, 8'h20);
    endtask

    task automatic t_wdog_off();
        wdog_en = 1'b0; wdog_expire = 1'b1;
        quiet("R5", 8'h20);
        wdog_expire = 1'b0; wdog_en = 1'b1;
    endtask

    task automatic t_multi();
        illop_req = 1'b1; clkmod_fault = 1'b1;
        hit("R3", 8'h14);
        illop_req = 1'b0; clkmod_fault = 1'b0;
        hold_len("R9", 16);
    endtask

    task automatic t_lv();
        lv_trip = 1'b1; lv_det_en = 1'b1; lv_rst_en = 1'b0;
        quiet("R6", 8'h14);
        lv_det_en = 1'b0; lv_rst_en = 1'b1;
        quiet("R6", 8'h14);
        lv_det_en = 1'b1;
        hit("R6", 8'h02);
        lv_trip = 1'b0;
        hold_len("R6", 16);
    endtask

    task automatic t_stop();
        stop_mode = 1'b1; lv_stop_en = 1'b0; lv_trip = 1'b1;
        quiet("R7", 8'h20);
        lv_stop_en = 1'b1;
        hit("R7", 8'h02);
        lv_trip = 1'b0;
        hold_len("R7", 16);
        stop_mode = 1'b0; lv_stop_en = 1'b0;
    endtask

    task automatic t_pin();
        ext_rst_n = 1'b0;
        @(negedge clk);
        chk("R8", "first sync stage", sys_rst, 0);
        @(negedge clk);
        chk("R8", "second sync stage", sys_rst, 0);
        hit("R8", 8'h40);
        ext_rst_n = 1'b1;
        hold_len("R8", 18);
    endtask

    task automatic t_dbg();
        dbg_force = 1'b1; wdog_expire = 1'b1;
        hit("R4", 8'h00);
        dbg_force = 1'b0; wdog_expire = 1'b0;
        hold_len("R4", 16);
        chk("R4", "byte stays clear", rd_data, 8'h00);
    endtask

    task automatic t_retrig();
        wdog_expire = 1'b1;
        hit("R3", 8'h20);
        wdog_expire = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9", "still in stretch", sys_rst, 1);
        illop_req = 1'b1;
        @(negedge clk);
        illop_req = 1'b0;
        chk("R11", "late source not captured", rd_data, 8'h20);
        hold_len("R9", 16);
        chk("R11", "byte after late source", rd_data, 8'h20);
    endtask

    task automatic t_bus();
        bus_wr = 1'b1;
        @(negedge clk);
        chk("R10", "strobe after write", wdog_clr, 1);
        bus_wr = 1'b0;
        @(negedge clk);
        chk("R10", "strobe single cycle", wdog_clr, 0);
        chk("R10", "byte unchanged by write", rd_data, 8'h20);
        bus_addr = 8'h19; bus_wr = 1'b1;
        @(negedge clk);
        chk("R10", "no strobe for other address", wdog_clr, 0);
        chk("R12", "other address reads zero", rd_data, 8'h00);
        bus_wr = 1'b0; bus_addr = STAT;
        @(negedge clk);
        chk("R12", "cause address reads byte", rd_data, 8'h20);
    endtask

    initial begin
        por_n = 1'b0; ext_rst_n = 1'b1; wdog_expire = 1'b0; wdog_en = 1'b0;
        illop_req = 1'b0; clkmod_fault = 1'b0; lv_trip = 1'b0; lv_det_en = 1'b0;
        lv_rst_en = 1'b0; lv_stop_en = 1'b0; stop_mode = 1'b0; dbg_force = 1'b0;
        bus_addr = STAT; bus_wr = 1'b0;
        t_por();
        wdog_reset();
        t_wdog_off();
        t_multi();
        t_lv();
        wdog_reset();
        t_stop();
        t_pin();
        t_dbg();
        t_retrig();
        t_bus();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule